// File: doc/BRIEF.md
# Half-Duplex Backpressure Collision Generator

This block applies receive-side backpressure on a half-duplex Ethernet link by forcing collisions. When the MAC decides that the receive path must be throttled, it raises a flow-control request. While that request is honoured, every receive packet that begins afterwards is answered with a jam burst, which makes the remote station back off and retry. A packet that was already arriving when the request took hold is let through untouched. Its loss through lack of receive buffer space is accepted, and nothing here tries to recover it.

The function works only when the port runs half-duplex and the flow-control enable bit is set. The transmit logic consumes the jam output and drives the jam pattern onto the medium. The jam lasts a fixed number of bit times, which is turned into byte-clock cycles by parameters. A two-bit state output shows whether the block is idle, holding off until the current packet ends, or forcing collisions.

Top module: `hd_backpressure`

## Requirements
- R1: After reset, `jam_o` is 0 and `bp_state_o` is 2'b00 (idle).
- R2: The function is active only when `half_duplex_i`, `fc_enable_i` and `fc_req_i` are all 1. When any of them is 0, `bp_state_o` returns to 2'b00 one clock later and no new jam starts.
- R3: When the function becomes active while `rx_active_i` is 0, `bp_state_o` becomes 2'b10 (forcing) one clock later.
- R4: When the function becomes active while `rx_active_i` is 1, `bp_state_o` becomes 2'b01 (holding), and the packet in progress receives no jam.
- R5: In the holding state (2'b01), the first clock edge that samples `rx_active_i` at 0 moves the state to 2'b10.
- R6: In the forcing state with the function active, a cycle with `rx_start_i` at 1 raises `jam_o` from the next clock for exactly JAM_BITS/BITS_PER_CLK consecutive cycles (4 by default). A start pulse during a jam does not extend it.
- R7: When the function becomes inactive, packets that start in the same cycle or later receive no jam.
- R8: A jam already running when the function becomes inactive still runs its full length.
- R9: `bp_state_o` never shows the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_duplex_i | input | 1 | Port runs in half-duplex mode |
| fc_enable_i | input | 1 | Enable bit for collision-based flow control |
| fc_req_i | input | 1 | Level request to enter the flow-control state |
| rx_start_i | input | 1 | One-cycle pulse in the first cycle of a receive packet |
| rx_active_i | input | 1 | High for every cycle of a receive packet, including its start cycle |
| jam_o | output | 1 | Forces a collision in the transmit logic while high |
| bp_state_o | output | 2 | 00 idle, 01 holding for current packet end, 10 forcing collisions |

## Verification
On every cycle, assertions check three things. A jam starts only one clock after a start pulse seen in the forcing state. Every jam burst is exactly the configured length. The state drops to idle one clock after the function becomes inactive and never shows the unused code. The bench's scenarios cover the rest: the sweep over all mode, enable and request combinations, the exemption of a packet caught in flight, the move from holding to forcing at packet end, and the way a jam outlives an exit request.

// File: rtl/fcbp_pkg.sv
package fcbp_pkg;
   typedef enum logic [1:0] {
      BP_IDLE  = 2'b00,
      BP_HOLD  = 2'b01,
      BP_FORCE = 2'b10
   } bp_state_e;
endpackage

// File: rtl/fcbp_ctrl_fsm.sv
module fcbp_ctrl_fsm
   import fcbp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      active_i,
   input  logic      rx_active_i,
   output bp_state_e state_o
);
   bp_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         BP_IDLE:  if (active_i) state_d = rx_active_i ? BP_HOLD : BP_FORCE;
         BP_HOLD:  if (!active_i) state_d = BP_IDLE;
                   else if (!rx_active_i) state_d = BP_FORCE;
         BP_FORCE: if (!active_i) state_d = BP_IDLE;
         default:  state_d = BP_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= BP_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   // R2: leaving the active condition always lands in idle
   p_off_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> state_q == BP_IDLE);
   // R9: unused code never reached
   p_legal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != 2'b11);
   // R5: holding leaves only through idle or forcing
   p_hold_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BP_HOLD && active_i && !rx_active_i) |=> state_q == BP_FORCE);
endmodule

// File: rtl/fcbp_jam_timer.sv
module fcbp_jam_timer #(
   parameter int JAM_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic jam_o
);
   localparam int CNT_W = $clog2(JAM_CYCLES + 1);

   generate
      if (JAM_CYCLES < 1) begin : g_bad_len
         $error("fcbp_jam_timer: JAM_CYCLES must be at least 1");
      end

      if (JAM_CYCLES == 1) begin : g_single
         logic jam_q;
         always_ff @(posedge clk) begin
            if (!rst_n) jam_q <= 1'b0;
            else        jam_q <= fire_i & ~jam_q;
         end
         assign jam_o = jam_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
            else if (fire_i)
               cnt_q <= CNT_W'(JAM_CYCLES);
         end
         assign jam_o = (cnt_q != '0);
      end
   endgenerate

   // run-length observer for the burst-length assertions
   logic [CNT_W:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)     run_q <= '0;
      else if (jam_o) run_q <= run_q + 1'b1;
      else            run_q <= '0;
   end

   // R6 / R8: every burst has exactly the configured length
   p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(jam_o) |-> run_q == (CNT_W+1)'(JAM_CYCLES));
   p_burst_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      jam_o |-> run_q < (CNT_W+1)'(JAM_CYCLES));
endmodule

// File: rtl/hd_backpressure.sv
module hd_backpressure
   import fcbp_pkg::*;
#(
   parameter int JAM_BITS     = 32,
   parameter int BITS_PER_CLK = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       half_duplex_i,
   input  logic       fc_enable_i,
   input  logic       fc_req_i,
   input  logic       rx_start_i,
   input  logic       rx_active_i,
   output logic       jam_o,
   output logic [1:0] bp_state_o
);
   localparam int JAM_CYCLES = JAM_BITS / BITS_PER_CLK;

   generate
      if (BITS_PER_CLK < 1 || (JAM_BITS % BITS_PER_CLK) != 0) begin : g_bad_ratio
         $error("hd_backpressure: JAM_BITS must be a multiple of BITS_PER_CLK");
      end
   endgenerate

   logic      active;
   logic      fire;
   bp_state_e state;

   assign active = half_duplex_i & fc_enable_i & fc_req_i;

   fcbp_ctrl_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (active),
      .rx_active_i(rx_active_i),
      .state_o    (state)
   );

   assign fire = active & rx_start_i & (state == BP_FORCE);

   fcbp_jam_timer #(.JAM_CYCLES(JAM_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .fire_i(fire),
      .jam_o (jam_o)
   );

   assign bp_state_o = state;

   // R6 / R7: a burst starts only after a start pulse in forcing state while active
   p_jam_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jam_o) |-> $past(rx_start_i && active && bp_state_o == 2'b10));
   // R4: no burst begins while holding for the exempt packet
   p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bp_state_o == 2'b01 |-> !$rose(jam_o));
endmodule

// File: tb/hd_backpressure_tb.sv
module hd_backpressure_tb_top;
   localparam int JAM_LEN = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic half_duplex_i = 1'b0, fc_enable_i = 1'b0, fc_req_i = 1'b0;
   logic rx_start_i = 1'b0, rx_active_i = 1'b0;
   logic jam_o;
   logic [1:0] bp_state_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   hd_backpressure dut_i (
      .clk(clk), .rst_n(rst_n), .half_duplex_i(half_duplex_i),
      .fc_enable_i(fc_enable_i), .fc_req_i(fc_req_i),
      .rx_start_i(rx_start_i), .rx_active_i(rx_active_i),
      .jam_o(jam_o), .bp_state_o(bp_state_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drives one packet of len cycles; returns jam cycle count and first jam offset.
   task automatic packet(input int len, output int cnt, output int first);
      cnt = 0; first = -1;
      @(negedge clk); rx_start_i = 1'b1; rx_active_i = 1'b1;
      @(negedge clk); rx_start_i = 1'b0;
      for (int i = 1; i <= len + JAM_LEN + 3; i++) begin
         if (jam_o) begin cnt++; if (first < 0) first = i; end
         if (i == len) rx_active_i = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      int cnt, first;
      repeat (3) @(negedge clk);
      check("R1 reset jam", jam_o, 0);
      check("R1 reset state", bp_state_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R3/R6: sweep every mode/enable/request combination
      for (int c = 0; c < 8; c++) begin
         int on;
         half_duplex_i = c[0]; fc_enable_i = c[1]; fc_req_i = c[2];
         on = (c == 7);
         repeat (2) @(negedge clk);
         check(on ? "R3 forcing state" : "R2 idle when off", bp_state_o, on ? 2 : 0);
         packet(3, cnt, first);
         check(on ? "R6 jam length" : "R2 no jam when off", cnt, on ? JAM_LEN : 0);
         if (on) check("R6 jam starts next clock", first, 1);
      end

      // R6: jam length independent of packet length
      for (int len = 1; len <= 6; len++) begin
         packet(len, cnt, first);
         check("R6 jam length sweep", cnt, JAM_LEN);
         check("R6 jam offset sweep", first, 1);
      end

      // R6: second start inside a jam does not extend it
      @(negedge clk); rx_start_i = 1'b1; rx_active_i = 1'b1;
      @(negedge clk); rx_start_i = 1'b0; rx_active_i = 1'b0;
      cnt = 0;
      for (int i = 1; i <= 8; i++) begin
         if (jam_o) cnt++;
         rx_start_i = (i == 2); rx_active_i = (i == 2);
         @(negedge clk);
      end
      check("R6 no extension", cnt, JAM_LEN);
      rx_start_i = 1'b0; rx_active_i = 1'b0;

      // R7/R8: exit during a jam
      @(negedge clk); rx_start_i = 1'b1; rx_active_i = 1'b1;
      @(negedge clk); rx_start_i = 1'b0; rx_active_i = 1'b0;
      cnt = 1; // jam already high here
      check("R8 jam started", jam_o, 1);
      fc_req_i = 1'b0;
      @(negedge clk);
      check("R7 idle after exit", bp_state_o, 0);
      for (int i = 0; i < 6; i++) begin
         if (jam_o) cnt++;
         @(negedge clk);
      end
      check("R8 jam completes after exit", cnt, JAM_LEN);
      packet(3, cnt, first);
      check("R7 no jam after exit", cnt, 0);

      // R7: exit in the same cycle as a start
      fc_req_i = 1'b1;
      repeat (2) @(negedge clk);
      fc_req_i = 1'b0; rx_start_i = 1'b1; rx_active_i = 1'b1;
      @(negedge clk); rx_start_i = 1'b0; rx_active_i = 1'b0;
      cnt = 0;
      for (int i = 0; i < 6; i++) begin if (jam_o) cnt++; @(negedge clk); end
      check("R7 same-cycle exit", cnt, 0);

      // R4/R5: enter while a packet is in flight
      @(negedge clk); rx_start_i = 1'b1; rx_active_i = 1'b1;
      @(negedge clk); rx_start_i = 1'b0; fc_req_i = 1'b1;
      @(negedge clk);
      check("R4 holding state", bp_state_o, 1);
      cnt = 0;
      for (int i = 0; i < 5; i++) begin if (jam_o) cnt++; @(negedge clk); end
      check("R4 holding still", bp_state_o, 1);
      rx_active_i = 1'b0;
      for (int i = 0; i < 3; i++) begin if (jam_o) cnt++; @(negedge clk); end
      check("R4 exempt packet not jammed", cnt, 0);
      check("R5 forcing after packet end", bp_state_o, 2);
      packet(4, cnt, first);
      check("R5 later packet jammed", cnt, JAM_LEN);

      // R2: hold state drops to idle when enable clears
      @(negedge clk); rx_start_i = 1'b1; rx_active_i = 1'b1;
      fc_req_i = 1'b0;
      @(negedge clk); rx_start_i = 1'b0;
      repeat (2) @(negedge clk);
      fc_req_i = 1'b1;
      @(negedge clk);
      check("R4 hold on re-entry", bp_state_o, 1);
      fc_enable_i = 1'b0;
      @(negedge clk);
      check("R2 hold to idle on disable", bp_state_o, 0);
      rx_active_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 state code idle", bp_state_o, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule